// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a 10-bit successive-approximation converter. Software reaches it through a four-entry byte-wide register file: a control word, a configuration word and a two-byte result pair. The control word holds the module enable, a start/busy bit, a sticky completion flag, a channel number and the low two bits of the clock select. The configuration word holds the result justification, the high clock-select bit and a four-bit pin configuration field. The block passes the pin configuration field on to the pin multiplexer outside it. Once started, the block times each conversion step with a per-bit clock. That clock is either the system clock divided by a power of two from 2 to 64, or a tick from a separate slow RC oscillator, already brought into the system clock domain. Each conversion drives a hold signal for the sample capacitor and a 10-bit trial code for the DAC, and it reads back a single comparator bit.

The sequencer is a five-state machine. S_IDLE waits for a start. On a start it moves to S_SETTLE when the RC source is selected, or straight to S_ARM when a divided clock is selected. S_SETTLE waits a fixed number of system cycles and then enters S_ARM. S_ARM ends on the first per-bit tick, which raises hold, presents the trial code 10'h200 and enters S_BITS. S_BITS takes one bit decision per tick, from bit 9 down to bit 0, and enters S_LAST after the decision on bit 0. On its tick, S_LAST loads the formatted result, clears busy, sets the flag and returns to S_IDLE. An abort returns any busy state to S_IDLE. An abort comes from a control write, or from sleep while a divided clock is selected.

The clock source has to be chosen by a write before the write that sets the start bit. The start write itself uses the clock selection already stored in the registers.

Top module: `sar_seq`

## Requirements
- R1: The clock select code is {config bit 6, control bits 7:6}. Codes 000, 100, 001, 101, 010 and 110 give a per-bit period of 2, 4, 8, 16, 32 and 64 system cycles. Codes x11 take one period per cycle in which rc_tick_i is high.
- R2: With a divided clock, a start write sampled at edge e0 produces per-bit ticks at edges e0+n·D. hold_o rises at tick 1, and busy clears at tick 12. With the RC clock, ticks are ignored for 4 system cycles after the start edge. After that, every cycle in which rc_tick_i is high is a tick.
- R3: At tick 1 the trial code becomes 10'h200. At each of ticks 2 to 11, the current trial bit is kept if cmp_i is 1 and cleared if it is 0, and the next lower bit is then set to 1. The final code equals the input level implied by cmp_i.
- R4: At tick 12 the result pair is loaded, busy (control bit 2) clears and the flag (control bit 1) sets, all on the same edge. The flag stays set until software writes 0 to it. irq_o equals the flag AND irq_en_i.
- R5: A control write with bit 2 = 0 or bit 0 = 0 while busy aborts the conversion. Busy clears, hold_o drops on the next edge, the result pair is unchanged and the flag is not set.
- R6: With config bit 7 = 1 the result sits in bits 9:0 of the 16-bit pair, and the top six bits are 0. With config bit 7 = 0 it sits in bits 15:6, and the low six bits are 0. The high byte is at address 2 and the low byte at address 3.
- R7: A control write with bit 2 = 1 starts nothing while the stored enable is 0, including the write that sets the enable. Busy stays 0.
- R8: sleep_i high while busy with a divided clock aborts the conversion on the next edge. The result pair is kept, the enable bit stays 1 and active_o drops to 0.
- R9: sleep_i high while busy with the RC clock lets the conversion finish. active_o stays 1 until busy clears and is 0 afterwards while sleep_i stays high.
- R10: Reset clears the control and configuration words and leaves the result pair unchanged. Writes to the result bytes take effect only while the enable is 0.
- R11: Addresses are 0 = control, 1 = config, 2 = result high, 3 = result low. Control reads as {clock select bits 1:0, channel 2:0, busy, flag, enable}. Config reads as {justify, clock select bit 2, 2'b00, pin configuration 3:0}. chan_o and pin_cfg_o show the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| rc_tick_i | input | 1 | One-cycle pulse per RC oscillator period |
| sleep_i | input | 1 | Device sleep request |
| cmp_i | input | 1 | Comparator: input at or above the trial level |
| irq_en_i | input | 1 | Completion interrupt enable |
| hold_o | output | 1 | Sample capacitor disconnected from the input |
| dac_code_o | output | 10 | Trial code for the DAC |
| chan_o | output | 3 | Selected analog channel |
| pin_cfg_o | output | 4 | Pin configuration field |
| active_o | output | 1 | Analog section powered |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The bench attacks the edges of the per-bit timing. It checks busy one cycle before and on the twelfth tick of a divide-by-16 conversion, so a sequencer that counts the first segment wrong, or stops after eleven periods, is caught. It converts full-scale and near-zero inputs in both justifications. Those runs show a wrong bit order, a wrong keep/clear rule or a shifted result byte. It aborts a conversion after hold has risen, once by a control write and once by sleep with a divided clock. In both cases a design that wrote back the partial code or set the flag would fail the result and flag checks. It also lets an RC-clocked conversion run on through sleep, and writes the result bytes while the module is enabled and across a reset, where a design that gated the wrong way would lose or corrupt the stored result.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned REG_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_RHI  = 2'd2;
    localparam logic [1:0] ADDR_RLO  = 2'd3;

    localparam int unsigned CTRL_EN   = 0;
    localparam int unsigned CTRL_FLAG = 1;
    localparam int unsigned CTRL_GO   = 2;
    localparam int unsigned CFG_CSHI  = 6;
    localparam int unsigned CFG_JUST  = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETTLE,
        S_ARM,
        S_BITS,
        S_LAST
    } sar_state_e;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int unsigned MAX_SHIFT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       rc_sel,
    input  logic [2:0] div_shift,
    input  logic       rc_tick,
    output logic       tick
);
    localparam int unsigned CW = MAX_SHIFT;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          div_hit;

    assign lim     = CW'((32'd1 << div_shift) - 32'd1);
    assign div_hit = (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || div_hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (rc_sel ? rc_tick : div_hit);

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm #(
    parameter int unsigned RES_W      = 10,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic             rc_sel,
    input  logic             cmp,
    output logic             busy,
    output logic             hold,
    output logic             done,
    output logic [RES_W-1:0] code
);
    import sar_pkg::*;

    localparam int unsigned IW  = $clog2(RES_W);
    localparam int unsigned WCW = $clog2(SETTLE_CYC + 1);

    sar_state_e       state_q, state_d;
    logic [RES_W-1:0] sar_q;
    logic [IW-1:0]    idx_q;
    logic [WCW-1:0]   wcnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = rc_sel ? S_SETTLE : S_ARM;
            S_SETTLE: if (wcnt_q == WCW'(SETTLE_CYC - 1)) state_d = S_ARM;
            S_ARM:    if (tick) state_d = S_BITS;
            S_BITS:   if (tick && idx_q == '0) state_d = S_LAST;
            S_LAST:   if (tick) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
        if (abort && state_q != S_IDLE) state_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q  <= '0;
            idx_q  <= '0;
            wcnt_q <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                wcnt_q <= '0;
            end else if (state_q == S_SETTLE) begin
                wcnt_q <= wcnt_q + 1'b1;
            end
            if (state_q == S_ARM && tick && !abort) begin
                sar_q <= {1'b1, {(RES_W-1){1'b0}}};
                idx_q <= IW'(RES_W - 1);
            end else if (state_q == S_BITS && tick && !abort) begin
                sar_q[idx_q] <= cmp;
                if (idx_q != '0) begin
                    sar_q[idx_q - 1'b1] <= 1'b1;
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy = (state_q != S_IDLE);
        hold = (state_q == S_BITS) || (state_q == S_LAST);
        done = (state_q == S_LAST) && tick && !abort;
        code = sar_q;
    end

endmodule

// File: rtl/sar_regs.sv
module sar_regs #(
    parameter int unsigned RES_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_addr,
    input  logic [sar_pkg::REG_W-1:0] wr_data,
    input  logic [1:0]               rd_addr,
    input  logic                     busy,
    input  logic                     done,
    input  logic [RES_W-1:0]         result,
    output logic [sar_pkg::REG_W-1:0] rd_data,
    output logic                     start,
    output logic                     abort_sw,
    output logic                     en,
    output logic                     flag,
    output logic                     just,
    output logic                     cs_hi,
    output logic [1:0]               cs_lo,
    output logic [2:0]               chan,
    output logic [3:0]               pcfg,
    output logic [2*sar_pkg::REG_W-1:0] res_pair
);
    import sar_pkg::*;

    localparam int unsigned PW  = 2 * REG_W;
    localparam int unsigned PAD = PW - RES_W;

    logic             wr_ctrl, wr_cfg;
    logic [REG_W-1:0] rhi_q, rlo_q;
    logic [PW-1:0]    fmt;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_cfg   = wr_en && (wr_addr == ADDR_CFG);
    assign start    = wr_ctrl && wr_data[CTRL_GO] && en && !busy;
    assign abort_sw = wr_ctrl && busy && (!wr_data[CTRL_GO] || !wr_data[CTRL_EN]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en    <= 1'b0;
            flag  <= 1'b0;
            chan  <= '0;
            cs_lo <= '0;
            just  <= 1'b0;
            cs_hi <= 1'b0;
            pcfg  <= '0;
        end else begin
            if (wr_ctrl) begin
                en    <= wr_data[CTRL_EN];
                chan  <= wr_data[5:3];
                cs_lo <= wr_data[7:6];
            end
            if (done)         flag <= 1'b1;
            else if (wr_ctrl) flag <= wr_data[CTRL_FLAG];
            if (wr_cfg) begin
                just  <= wr_data[CFG_JUST];
                cs_hi <= wr_data[CFG_CSHI];
                pcfg  <= wr_data[3:0];
            end
        end
    end

    always_comb begin
        fmt = just ? {{PAD{1'b0}}, result} : {result, {PAD{1'b0}}};
    end

    // result pair has no reset: it survives reset as general storage
    always_ff @(posedge clk) begin
        if (done) begin
            rhi_q <= fmt[PW-1:REG_W];
            rlo_q <= fmt[REG_W-1:0];
        end else if (wr_en && !en) begin
            if (wr_addr == ADDR_RHI) rhi_q <= wr_data;
            if (wr_addr == ADDR_RLO) rlo_q <= wr_data;
        end
    end

    assign res_pair = {rhi_q, rlo_q};

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = {cs_lo, chan, busy, flag, en};
            ADDR_CFG:  rd_data = {just, cs_hi, 2'b00, pcfg};
            ADDR_RHI:  rd_data = rhi_q;
            default:   rd_data = rlo_q;
        endcase
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int unsigned RES_W      = 10,
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned MAX_SHIFT  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic             rc_tick_i,
    input  logic             sleep_i,
    input  logic             cmp_i,
    input  logic             irq_en_i,
    output logic             hold_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic [2:0]       chan_o,
    output logic [3:0]       pin_cfg_o,
    output logic             active_o,
    output logic             irq_o
);
    logic             start, abort_sw, abort, sleep_abort;
    logic             en, flag, just, cs_hi;
    logic [1:0]       cs_lo;
    logic [2:0]       chan;
    logic [3:0]       pcfg;
    logic [15:0]      res_pair;
    logic             busy, done, tick, rc_sel;
    logic [2:0]       div_shift;
    logic [RES_W-1:0] code;

    assign rc_sel      = (cs_lo == 2'b11);
    assign div_shift   = 3'd1 + {2'b00, cs_hi} + {cs_lo, 1'b0};
    assign sleep_abort = sleep_i && !rc_sel && busy;
    assign abort       = abort_sw || sleep_abort;

    sar_regs #(.RES_W(RES_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .busy(busy), .done(done), .result(code),
        .rd_data(rd_data), .start(start), .abort_sw(abort_sw),
        .en(en), .flag(flag), .just(just), .cs_hi(cs_hi), .cs_lo(cs_lo),
        .chan(chan), .pcfg(pcfg), .res_pair(res_pair)
    );

    sar_tick_gen #(.MAX_SHIFT(MAX_SHIFT)) tick_i (
        .clk(clk), .rst_n(rst_n), .restart(start), .run(busy),
        .rc_sel(rc_sel), .div_shift(div_shift), .rc_tick(rc_tick_i),
        .tick(tick)
    );

    sar_fsm #(.RES_W(RES_W), .SETTLE_CYC(SETTLE_CYC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .tick(tick), .rc_sel(rc_sel), .cmp(cmp_i),
        .busy(busy), .hold(hold_o), .done(done), .code(code)
    );

    assign dac_code_o = code;
    assign chan_o     = chan;
    assign pin_cfg_o  = pcfg;
    assign active_o   = en && (!sleep_i || busy);
    assign irq_o      = flag && irq_en_i;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int unsigned RES_W = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        abort,
    input logic        hold,
    input logic        en,
    input logic        flag,
    input logic        just,
    input logic        rc_sel,
    input logic        sleep_i,
    input logic [15:0] res_pair
);
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en)); // R7

    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (flag && !busy)); // R4

    AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> $stable(res_pair)); // R5

    AST_ABORT_RELEASES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> !hold); // R5

    AST_SLEEP_ABORTS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !rc_sel && busy) |=> !busy); // R8

    AST_RIGHT_JUST_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && just) |=> (res_pair[15:RES_W] == '0)); // R6

endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .abort(abort),
    .hold(hold_o), .en(en), .flag(flag), .just(just), .rc_sel(rc_sel),
    .sleep_i(sleep_i), .res_pair(res_pair)
);

// File: tb/sar_seq_tb.sv
`timescale 1ns/100ps
module sar_seq_tb_top;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rc_tick_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       cmp_i;
    logic       irq_en_i = 1'b1;
    logic       hold_o;
    logic [9:0] dac_code_o;
    logic [2:0] chan_o;
    logic [3:0] pin_cfg_o;
    logic       active_o, irq_o;

    int vin = 0;
    int tests = 0;
    int fails = 0;
    int rc_div = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign cmp_i = (vin >= int'(dac_code_o));

    sar_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rc_tick_i(rc_tick_i), .sleep_i(sleep_i), .cmp_i(cmp_i),
        .irq_en_i(irq_en_i), .hold_o(hold_o), .dac_code_o(dac_code_o),
        .chan_o(chan_o), .pin_cfg_o(pin_cfg_o), .active_o(active_o),
        .irq_o(irq_o)
    );

    always @(posedge clk) begin
        #1;
        rc_div = rc_div + 1;
        rc_tick_i = (rc_div % 7 == 0);
    end

    // behavioural reference model
    bit        m_en = 0, m_flag = 0, m_just = 0, m_cs_hi = 0, m_hold = 0;
    bit [1:0]  m_cs_lo = 0;
    bit [2:0]  m_chan = 0;
    bit [3:0]  m_pcfg = 0;
    int        m_phase = 0, m_wait = 0, m_cyc = 0, m_n = 0, m_code = 0;
    bit [15:0] m_res = 0;
    bit        m_hi_ok = 0, m_lo_ok = 0;

    function automatic bit [7:0] m_rd(input bit [1:0] a);
        case (a)
            2'd0:    return {m_cs_lo, m_chan, (m_phase != 0), m_flag, m_en};
            2'd1:    return {m_just, m_cs_hi, 2'b00, m_pcfg};
            2'd2:    return m_res[15:8];
            default: return m_res[7:0];
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_flag = 0; m_just = 0; m_cs_hi = 0; m_cs_lo = 0;
            m_chan = 0; m_pcfg = 0; m_phase = 0; m_hold = 0; m_code = 0;
        end else begin
            int  ph;
            bit  rc, tk, fin, abt, go, en_old;
            int  d, b;
            ph = m_phase; rc = (m_cs_lo == 2'b11); en_old = m_en;
            d = 1 << (1 + m_cs_hi + 2 * m_cs_lo);
            tk = 0; fin = 0; abt = 0; go = 0;
            if (ph == 2) begin
                if (rc) tk = rc_tick_i;
                else begin
                    m_cyc = m_cyc + 1;
                    if (m_cyc == d) begin tk = 1; m_cyc = 0; end
                end
            end
            if (wr_en && wr_addr == 0 && ph != 0 && (!wr_data[2] || !wr_data[0])) abt = 1;
            if (sleep_i && !rc && ph != 0) abt = 1;
            if (wr_en && wr_addr == 0 && wr_data[2] && m_en && ph == 0) go = 1;
            if (abt) begin
                m_phase = 0; m_hold = 0;
            end else if (ph == 1) begin
                m_wait = m_wait + 1;
                if (m_wait == SETTLE) m_phase = 2;
            end else if (ph == 2 && tk) begin
                m_n = m_n + 1;
                if (m_n == 1) begin
                    m_hold = 1; m_code = 512;
                end else if (m_n <= 11) begin
                    b = 11 - m_n;
                    if (!(vin >= m_code)) m_code = m_code - (1 << b);
                    if (b > 0) m_code = m_code + (1 << (b - 1));
                end else begin
                    fin = 1; m_phase = 0; m_hold = 0;
                    m_res = m_just ? 16'(m_code) : 16'(m_code << 6);
                    m_hi_ok = 1; m_lo_ok = 1;
                end
            end
            if (go) begin
                m_phase = rc ? 1 : 2; m_wait = 0; m_cyc = 0; m_n = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_en = wr_data[0]; m_flag = wr_data[1];
                        m_chan = wr_data[5:3]; m_cs_lo = wr_data[7:6];
                    end
                    2'd1: begin
                        m_just = wr_data[7]; m_cs_hi = wr_data[6]; m_pcfg = wr_data[3:0];
                    end
                    2'd2: if (!en_old) begin m_res[15:8] = wr_data; m_hi_ok = 1; end
                    default: if (!en_old) begin m_res[7:0] = wr_data; m_lo_ok = 1; end
                endcase
            end
            if (fin) m_flag = 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit bad;
            bad = 0;
            tests++;
            if (hold_o !== m_hold) begin
                bad = 1; $display("FAIL R2 hold_o actual=%0b expected=%0b", hold_o, m_hold);
            end
            if (int'(dac_code_o) != m_code || $isunknown(dac_code_o)) begin
                bad = 1; $display("FAIL R3 dac_code_o actual=%0h expected=%0h", dac_code_o, m_code);
            end
            if (irq_o !== (m_flag && irq_en_i)) begin
                bad = 1; $display("FAIL R4 irq_o actual=%0b expected=%0b", irq_o, m_flag && irq_en_i);
            end
            if (active_o !== (m_en && (!sleep_i || m_phase != 0))) begin
                bad = 1; $display("FAIL R8 active_o actual=%0b expected=%0b", active_o,
                                  m_en && (!sleep_i || m_phase != 0));
            end
            if (chan_o !== m_chan || pin_cfg_o !== m_pcfg) begin
                bad = 1; $display("FAIL R11 fields actual=%0h/%0h expected=%0h/%0h",
                                  chan_o, pin_cfg_o, m_chan, m_pcfg);
            end
            if ((rd_addr < 2) || (rd_addr == 2 && m_hi_ok) || (rd_addr == 3 && m_lo_ok)) begin
                if (rd_data !== m_rd(rd_addr)) begin
                    bad = 1; $display("FAIL R11 rd_data[%0d] actual=%0h expected=%0h",
                                      rd_addr, rd_data, m_rd(rd_addr));
                end
            end
            if (bad) fails++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input bit [1:0] a, output bit [7:0] d);
        @(posedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic wait_idle(input int limit);
        rd_addr = 2'd0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (rd_data[2] == 1'b0) break;
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R2 watchdog expired");
        summary();
    end

    initial begin
        bit [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10 reset state
        rd(2'd0, v); check("R10 ctrl after reset", v, 8'h00);
        rd(2'd1, v); check("R10 cfg after reset", v, 8'h00);

        // R10 result bytes as storage while disabled
        wr(2'd2, 8'hA5); wr(2'd3, 8'h3C);
        rd(2'd2, v); check("R10 result high storage", v, 8'hA5);
        rd(2'd3, v); check("R10 result low storage", v, 8'h3C);

        // R7 start ignored while disabled, also in the enabling write
        wr(2'd0, 8'h04); rd(2'd0, v); check("R7 go with enable 0", v[2], 0);
        wr(2'd0, 8'h05); rd(2'd0, v); check("R7 go in enabling write", v[2], 0);
        check("R7 hold stays low", hold_o, 0);

        // R1 R3 R6 divide-by-2, right justified, channel field
        wr(2'd1, 8'h85); wr(2'd0, 8'h29);
        check("R11 chan_o", chan_o, 5);
        check("R11 pin_cfg_o", pin_cfg_o, 5);
        vin = 10'h2B7;
        wr(2'd0, 8'h2D);
        wait_idle(200);
        rd(2'd2, v); check("R6 right justified high", v, 8'h02);
        rd(2'd3, v); check("R3 right justified low", v, 8'hB7);
        rd(2'd0, v); check("R4 flag set on completion", v[1], 1);
        check("R4 irq_o with enable", irq_o, 1);
        @(posedge clk); #1 irq_en_i = 0;
        @(negedge clk); check("R4 irq_o masked", irq_o, 0);
        @(posedge clk); #1 irq_en_i = 1;
        @(negedge clk); check("R4 flag sticky", irq_o, 1);
        wr(2'd0, 8'h01);
        @(negedge clk); check("R4 flag cleared by write", irq_o, 0);

        // R1 R2 R6 divide-by-16 timing, left justified, full scale
        wr(2'd1, 8'h40); wr(2'd0, 8'h41);
        vin = 10'h3FF;
        rd_addr = 2'd0;
        wr(2'd0, 8'h45);
        repeat (12 * 16 - 1) @(posedge clk);
        #1 check("R2 busy before tick 12", rd_data[2], 1);
        check("R2 hold before tick 12", hold_o, 1);
        @(posedge clk); #1;
        check("R2 busy cleared at tick 12", rd_data[2], 0);
        check("R4 flag at tick 12", rd_data[1], 1);
        rd(2'd2, v); check("R6 left justified high", v, 8'hFF);
        rd(2'd3, v); check("R6 left justified low", v, 8'hC0);

        // R5 abort by write after hold has risen (divide-by-8)
        wr(2'd1, 8'h00); wr(2'd0, 8'h41);
        vin = 10'h155;
        wr(2'd0, 8'h45);
        repeat (40) @(posedge clk);
        check("R5 hold before abort", hold_o, 1);
        wr(2'd0, 8'h41);
        rd(2'd0, v); check("R5 busy cleared by abort", v[2], 0);
        check("R5 flag not set by abort", v[1], 0);
        check("R5 hold released", hold_o, 0);
        rd(2'd2, v); check("R5 result high kept", v, 8'hFF);
        rd(2'd3, v); check("R5 result low kept", v, 8'hC0);

        // R10 result write ignored while enabled
        wr(2'd2, 8'h11);
        rd(2'd2, v); check("R10 result write while enabled", v, 8'hFF);

        // R8 sleep with divided clock (divide-by-4)
        wr(2'd1, 8'h40); wr(2'd0, 8'h01);
        wr(2'd0, 8'h05);
        repeat (10) @(posedge clk);
        #1 sleep_i = 1;
        rd(2'd0, v);
        check("R8 busy cleared by sleep", v[2], 0);
        check("R8 enable kept", v[0], 1);
        check("R8 active_o low", active_o, 0);
        rd(2'd3, v); check("R8 result kept", v, 8'hC0);
        @(posedge clk); #1 sleep_i = 0;

        // R9 RC clock continues through sleep, near-zero input
        wr(2'd1, 8'h80); wr(2'd0, 8'hC1);
        vin = 10'h001;
        wr(2'd0, 8'hC5);
        @(posedge clk); #1 sleep_i = 1;
        repeat (30) @(posedge clk);
        rd(2'd0, v);
        check("R9 busy during sleep", v[2], 1);
        check("R9 active_o during sleep", active_o, 1);
        wait_idle(400);
        @(negedge clk);
        check("R9 active_o after completion", active_o, 0);
        rd(2'd0, v); check("R9 flag after completion", v[1], 1);
        rd(2'd2, v); check("R9 result high", v, 8'h00);
        rd(2'd3, v); check("R9 result low", v, 8'h01);
        @(posedge clk); #1 sleep_i = 0;

        // R10 reset keeps the result pair
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h5A);
        @(posedge clk); #1 rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        rd(2'd0, v); check("R10 ctrl cleared by reset", v, 8'h00);
        rd(2'd1, v); check("R10 cfg cleared by reset", v, 8'h00);
        rd(2'd2, v); check("R10 result high survives reset", v, 8'h5A);
        rd(2'd3, v); check("R10 result low survives reset", v, 8'h01);

        repeat (4) @(posedge clk);
        summary();
    end

endmodule